// File: doc/BRIEF.md
# Privilege Level Exception Controller

This block holds the privilege state of a small processor model: a current level from 0 (least trusted) to 3 (most trusted) and a stack-select bit. Both are packed into one 4-bit mode value. The block takes exceptions upward and returns downward. For each level it keeps a banked saved return address and a banked saved mode. On every accepted transfer it issues a new program counter, which is either a vector address or a saved return address.

The surrounding core supplies the current program counter and a trap request with a kind code. It also supplies a return request, and write ports through which supervisor code prepares the banked registers before a return. The outputs are registered and change one clock after the request. They are the program counter with a load strobe, the level, the mode, the active stack-pointer index, a read-only status word, and two one-cycle flags for rejected traps and rejected returns.

Top module: `priv_exc_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the mode to 0b1101 (level 3, dedicated stack), clears pc_out, pc_load and both illegal flags, and zeroes every banked return address and saved mode.
- R2: The mode holds the level in bits [3:2] and the stack select in bit 0, with bit 1 always zero. The legal values are 0000, 0100, 0101, 1000, 1001, 1100 and 1101. sp_sel equals the level when bit 0 is 1 and equals 0 when bit 0 is 0.
- R3: status_word carries the current level in bits [3:2] and zero in every other bit.
- R4: An accepted trap does the following. It writes pc_in into the target level's saved return address and the current mode into that level's saved mode. It sets the mode to the target level with bit 0 set. It loads pc_out with VEC_BASE + target*VEC_STRIDE and pulses pc_load, all one cycle after the request.
- R5: Call kind codes: 0 is accepted only at level 0 and targets level 1; 1 is accepted only at level 1 and targets level 2; 2 is accepted only at level 2 and targets level 3.
- R6: Kind 3 (interrupt) and kind 4 (synchronous fault) are always accepted. They target level 1 from level 0 and level 2 from level 1, and they stay at the current level from level 2 or level 3. Level 3 is never entered by them.
- R7: A call at the wrong level, or a kind code of 5 to 7, pulses illegal_trap for one cycle. It leaves the mode, pc_out and the banked registers unchanged and does not pulse pc_load.
- R8: An accepted return loads the mode from the current level's saved mode and pc_out from its saved return address, and pulses pc_load. It may drop any number of levels or stay at the same level.
- R9: A return is rejected when it is requested at level 0, when the saved mode is not a legal value, or when the saved mode names a level above the current one. A rejected return pulses illegal_ret and changes neither the mode nor pc_out.
- R10: wr_ret_en and wr_st_en write the banked return address and saved mode of level wr_lvl. When an accepted trap writes the same level in the same cycle, the trap's values are kept.
- R11: When trap_req and ret_req are both high, only the trap is considered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_in | input | PC_W | Program counter of the requesting instruction |
| trap_req | input | 1 | Exception request |
| trap_kind | input | 3 | 0 supervisor call, 1 hypervisor call, 2 monitor call, 3 interrupt, 4 fault |
| ret_req | input | 1 | Exception return request |
| wr_ret_en | input | 1 | Write enable for a banked return address |
| wr_st_en | input | 1 | Write enable for a banked saved mode |
| wr_lvl | input | 2 | Level whose banked registers are written |
| wr_ret_data | input | PC_W | Return address write data |
| wr_st_data | input | 4 | Saved mode write data |
| pc_out | output | PC_W | New program counter |
| pc_load | output | 1 | One-cycle strobe: pc_out is to be taken |
| cur_level | output | 2 | Current privilege level |
| mode | output | 4 | Packed mode value |
| sp_sel | output | 2 | Index of the active stack pointer |
| status_word | output | STAT_W | Read-only current-level status |
| illegal_trap | output | 1 | One-cycle flag: trap rejected |
| illegal_ret | output | 1 | One-cycle flag: return rejected |

## Verification
A corrupted mode register shows up on the mode, sp_sel and status_word ports in the same cycle. It then shows up again on the next transfer, as a wrong vector or a wrong rejection decision. A wrong banked write cannot be seen at once. It surfaces only at the return from that level, possibly many transfers later, as a wrong pc_out or a wrong restored mode. For that reason, every trap in the directed sequence is later unwound by a return whose destination is predicted.

// File: rtl/priv_pkg.sv
`timescale 1ns/1ps
package priv_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int MODE_W  = LVL_W + 2;

  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [MODE_W-1:0] mode_t;

  typedef enum logic [2:0] {
    K_SUPCALL = 3'd0,
    K_HYPCALL = 3'd1,
    K_MONCALL = 3'd2,
    K_IRQ     = 3'd3,
    K_FAULT   = 3'd4
  } trap_kind_e;

  // bit 1 reserved zero; level 0 has no dedicated stack
  function automatic logic mode_legal(input mode_t m);
    return (m[1] == 1'b0) && !((m[3:2] == 2'b00) && m[0]);
  endfunction
endpackage

// File: rtl/priv_decode.sv
`timescale 1ns/1ps
module priv_decode
  import priv_pkg::*;
(
  input  mode_t      cur_mode,
  input  logic [2:0] kind,
  input  mode_t      saved_mode,
  output logic       trap_ok,
  output lvl_t       trap_tgt,
  output logic       ret_ok
);
  lvl_t cur;
  assign cur = cur_mode[3:2];

  always_comb begin
    trap_ok  = 1'b0;
    trap_tgt = cur;
    case (trap_kind_e'(kind))
      K_SUPCALL: if (cur == 2'd0) begin trap_ok = 1'b1; trap_tgt = 2'd1; end
      K_HYPCALL: if (cur == 2'd1) begin trap_ok = 1'b1; trap_tgt = 2'd2; end
      K_MONCALL: if (cur == 2'd2) begin trap_ok = 1'b1; trap_tgt = 2'd3; end
      K_IRQ, K_FAULT: begin
        trap_ok  = 1'b1;
        trap_tgt = (cur == 2'd0) ? 2'd1 : (cur == 2'd1) ? 2'd2 : cur;
      end
      default: ;
    endcase
  end

  assign ret_ok = (cur != 2'd0) && mode_legal(saved_mode) && (saved_mode[3:2] <= cur);
endmodule

// File: rtl/priv_bank.sv
`timescale 1ns/1ps
module priv_bank
  import priv_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ent_en,
  input  lvl_t            ent_lvl,
  input  logic [PC_W-1:0] ent_ret,
  input  mode_t           ent_mode,
  input  logic            wr_ret_en,
  input  logic            wr_st_en,
  input  lvl_t            wr_lvl,
  input  logic [PC_W-1:0] wr_ret_data,
  input  mode_t           wr_st_data,
  input  lvl_t            rd_lvl,
  output logic [PC_W-1:0] rd_ret,
  output mode_t           rd_mode
);
  logic [PC_W-1:0] ret_vec  [NUM_LVL];
  mode_t           mode_vec [NUM_LVL];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic [PC_W-1:0] ret_q;
    mode_t           mode_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        ret_q  <= '0;
        mode_q <= '0;
      end else if (ent_en && ent_lvl == lvl_t'(g)) begin
        ret_q  <= ent_ret;
        mode_q <= ent_mode;
      end else begin
        if (wr_ret_en && wr_lvl == lvl_t'(g)) ret_q  <= wr_ret_data;
        if (wr_st_en  && wr_lvl == lvl_t'(g)) mode_q <= wr_st_data;
      end
    end
    assign ret_vec[g]  = ret_q;
    assign mode_vec[g] = mode_q;
  end

  assign rd_ret  = ret_vec[rd_lvl];
  assign rd_mode = mode_vec[rd_lvl];
endmodule

// File: rtl/priv_exc_ctrl.sv
`timescale 1ns/1ps
module priv_exc_ctrl
  import priv_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int STAT_W     = 8,
  parameter int VEC_BASE   = 'h1000,
  parameter int VEC_STRIDE = 'h200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              trap_req,
  input  logic [2:0]        trap_kind,
  input  logic              ret_req,
  input  logic              wr_ret_en,
  input  logic              wr_st_en,
  input  logic [1:0]        wr_lvl,
  input  logic [PC_W-1:0]   wr_ret_data,
  input  logic [3:0]        wr_st_data,
  output logic [PC_W-1:0]   pc_out,
  output logic              pc_load,
  output logic [1:0]        cur_level,
  output logic [3:0]        mode,
  output logic [1:0]        sp_sel,
  output logic [STAT_W-1:0] status_word,
  output logic              illegal_trap,
  output logic              illegal_ret
);
  localparam mode_t           RESET_MODE = 4'b1101;
  localparam logic [PC_W-1:0] VB = PC_W'(VEC_BASE);
  localparam logic [PC_W-1:0] VS = PC_W'(VEC_STRIDE);

  mode_t           mode_q;
  logic            trap_ok, ret_ok, take_trap;
  lvl_t            trap_tgt;
  logic [PC_W-1:0] bank_ret;
  mode_t           bank_mode;

  assign take_trap = trap_req && trap_ok;

  priv_decode u_dec (
    .cur_mode  (mode_q),
    .kind      (trap_kind),
    .saved_mode(bank_mode),
    .trap_ok   (trap_ok),
    .trap_tgt  (trap_tgt),
    .ret_ok    (ret_ok)
  );

  priv_bank #(.PC_W(PC_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .ent_en     (take_trap),
    .ent_lvl    (trap_tgt),
    .ent_ret    (pc_in),
    .ent_mode   (mode_q),
    .wr_ret_en  (wr_ret_en),
    .wr_st_en   (wr_st_en),
    .wr_lvl     (wr_lvl),
    .wr_ret_data(wr_ret_data),
    .wr_st_data (wr_st_data),
    .rd_lvl     (mode_q[3:2]),
    .rd_ret     (bank_ret),
    .rd_mode    (bank_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= RESET_MODE;
      pc_out       <= '0;
      pc_load      <= 1'b0;
      illegal_trap <= 1'b0;
      illegal_ret  <= 1'b0;
    end else begin
      pc_load      <= 1'b0;
      illegal_trap <= 1'b0;
      illegal_ret  <= 1'b0;
      if (trap_req) begin
        if (trap_ok) begin
          mode_q  <= {trap_tgt, 2'b01};
          pc_out  <= VB + VS * PC_W'(trap_tgt);
          pc_load <= 1'b1;
        end else begin
          illegal_trap <= 1'b1;
        end
      end else if (ret_req) begin
        if (ret_ok) begin
          mode_q  <= bank_mode;
          pc_out  <= bank_ret;
          pc_load <= 1'b1;
        end else begin
          illegal_ret <= 1'b1;
        end
      end
    end
  end

  assign mode        = mode_q;
  assign cur_level   = mode_q[3:2];
  assign sp_sel      = mode_q[0] ? mode_q[3:2] : 2'b00;
  assign status_word = STAT_W'({mode_q[3:2], 2'b00});

  a_r2_mode_legal: assert property (@(posedge clk) disable iff (rst)
    mode_legal(mode_q));

  a_r5_one_hop_up: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> ({1'b0, mode_q[3:2]} <= {1'b0, $past(mode_q[3:2])} + 3'd1));

  a_r8_ret_never_up: assert property (@(posedge clk) disable iff (rst)
    (ret_req && !trap_req) |=> (mode_q[3:2] <= $past(mode_q[3:2])));

  a_r4_entry_dedicated: assert property (@(posedge clk) disable iff (rst)
    (pc_load && $past(trap_req)) |-> mode_q[0]);

  a_r9_bad_ret_holds: assert property (@(posedge clk) disable iff (rst)
    illegal_ret |-> ($stable(mode_q) && !pc_load));

  a_r7_bad_trap_holds: assert property (@(posedge clk) disable iff (rst)
    illegal_trap |-> ($stable(mode_q) && !pc_load));
endmodule

// File: tb/priv_exc_ctrl_bench.sv
`timescale 1ns/1ps
module priv_exc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_in = '0;
  logic        trap_req = 1'b0;
  logic [2:0]  trap_kind = '0;
  logic        ret_req = 1'b0;
  logic        wr_ret_en = 1'b0, wr_st_en = 1'b0;
  logic [1:0]  wr_lvl = '0;
  logic [31:0] wr_ret_data = '0;
  logic [3:0]  wr_st_data = '0;
  logic [31:0] pc_out;
  logic        pc_load, illegal_trap, illegal_ret;
  logic [1:0]  cur_level, sp_sel;
  logic [3:0]  mode;
  logic [7:0]  status_word;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  priv_exc_ctrl u_priv_exc_ctrl (
    .clk(clk), .rst(rst), .pc_in(pc_in), .trap_req(trap_req), .trap_kind(trap_kind),
    .ret_req(ret_req), .wr_ret_en(wr_ret_en), .wr_st_en(wr_st_en), .wr_lvl(wr_lvl),
    .wr_ret_data(wr_ret_data), .wr_st_data(wr_st_data), .pc_out(pc_out),
    .pc_load(pc_load), .cur_level(cur_level), .mode(mode), .sp_sel(sp_sel),
    .status_word(status_word), .illegal_trap(illegal_trap), .illegal_ret(illegal_ret)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // full port view; sp and status predicted from R2/R3
  task automatic see(input string req, input logic [3:0] m, input logic [31:0] pc,
                     input logic ld, input logic it, input logic ir);
    chk(req, "mode", 32'(mode), 32'(m));
    chk(req, "level", 32'(cur_level), 32'(m[3:2]));
    chk(req, "sp_sel", 32'(sp_sel), m[0] ? 32'(m[3:2]) : 32'd0);
    chk(req, "status", 32'(status_word), 32'(m[3:2]) << 2);
    chk(req, "pc_out", pc_out, pc);
    chk(req, "pc_load", 32'(pc_load), 32'(ld));
    chk(req, "illegal_trap", 32'(illegal_trap), 32'(it));
    chk(req, "illegal_ret", 32'(illegal_ret), 32'(ir));
  endtask

  task automatic trap(input logic [2:0] k, input logic [31:0] pc);
    trap_req = 1'b1; trap_kind = k; pc_in = pc;
    @(negedge clk);
    trap_req = 1'b0;
  endtask

  task automatic ret();
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
  endtask

  task automatic wr(input logic [1:0] l, input logic [31:0] a, input logic [3:0] m);
    wr_ret_en = 1'b1; wr_st_en = 1'b1; wr_lvl = l; wr_ret_data = a; wr_st_data = m;
    @(negedge clk);
    wr_ret_en = 1'b0; wr_st_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    see("R1", 4'b1101, 32'h0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    see("R3", 4'b1101, 32'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_cleared_banks();
    ret();  // R1: cleared level-3 bank returns to mode 0000, pc 0
    see("R1", 4'b0000, 32'h0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_l0_return();
    ret();
    see("R9", 4'b0000, 32'h0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_bad_calls_l0();
    trap(3'd1, 32'h80);
    see("R7", 4'b0000, 32'h0, 1'b0, 1'b1, 1'b0);
    trap(3'd6, 32'h84);
    see("R7", 4'b0000, 32'h0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_calls_up();
    trap(3'd0, 32'h100);
    see("R5", 4'b0101, 32'h1200, 1'b1, 1'b0, 1'b0);
    trap(3'd1, 32'h1210);
    see("R4", 4'b1001, 32'h1400, 1'b1, 1'b0, 1'b0);
    trap(3'd2, 32'h1410);
    see("R5", 4'b1101, 32'h1600, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_returns_down();
    ret();
    see("R8", 4'b1001, 32'h1410, 1'b1, 1'b0, 1'b0);
    ret();
    see("R8", 4'b0101, 32'h1210, 1'b1, 1'b0, 1'b0);
    ret();
    see("R4", 4'b0000, 32'h100, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_async();
    trap(3'd3, 32'h104);
    see("R6", 4'b0101, 32'h1200, 1'b1, 1'b0, 1'b0);
    trap(3'd3, 32'h1204);
    see("R6", 4'b1001, 32'h1400, 1'b1, 1'b0, 1'b0);
    trap(3'd4, 32'h1404);
    see("R6", 4'b1001, 32'h1400, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_bad_call_l2();
    trap(3'd0, 32'h1408);
    see("R7", 4'b1001, 32'h1400, 1'b0, 1'b1, 1'b0);
    ret();  // bank of level 2 still holds the fault's entry
    see("R7", 4'b1001, 32'h1404, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_sw_writes();
    wr(2'd2, 32'h2000, 4'b1101);
    ret();
    see("R9", 4'b1001, 32'h1404, 1'b0, 1'b0, 1'b1);
    wr(2'd2, 32'h2000, 4'b0011);
    ret();
    see("R9", 4'b1001, 32'h1404, 1'b0, 1'b0, 1'b1);
    wr(2'd2, 32'h2000, 4'b0100);
    ret();
    see("R10", 4'b0100, 32'h2000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_deep_drop();
    trap(3'd1, 32'h2004);
    see("R5", 4'b1001, 32'h1400, 1'b1, 1'b0, 1'b0);
    trap(3'd2, 32'h1408);
    see("R5", 4'b1101, 32'h1600, 1'b1, 1'b0, 1'b0);
    wr(2'd3, 32'h3000, 4'b0000);
    ret();
    see("R8", 4'b0000, 32'h3000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_collision();
    wr_ret_en = 1'b1; wr_st_en = 1'b1; wr_lvl = 2'd1;
    wr_ret_data = 32'hDEAD; wr_st_data = 4'b1101;
    trap(3'd0, 32'h40);
    wr_ret_en = 1'b0; wr_st_en = 1'b0;
    see("R10", 4'b0101, 32'h1200, 1'b1, 1'b0, 1'b0);
    ret();
    see("R10", 4'b0000, 32'h40, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_priority();
    ret_req = 1'b1;
    trap(3'd0, 32'h44);
    ret_req = 1'b0;
    see("R11", 4'b0101, 32'h1200, 1'b1, 1'b0, 1'b0);
    ret();
    see("R11", 4'b0000, 32'h44, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_cleared_banks();
    t_l0_return();
    t_bad_calls_l0();
    t_calls_up();
    t_returns_down();
    t_async();
    t_bad_call_l2();
    t_sw_writes();
    t_deep_drop();
    t_collision();
    t_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule